// File: doc/BRIEF.md
# Programmable Word-Wide CRC Engine

A register-mapped CRC unit that folds one 32-bit word into a running checksum every clock. Software sets a start value and a generator polynomial, then issues a control write that restarts the checksum and, if it chooses, turns on reflected operation. After that, each write to the data register advances the checksum by one word. Reading that same register gives the current result.

Because both the polynomial and the start value are registers, one engine computes several CRC variants. In reflected mode each input word is bit-reversed before it is folded in, and the value read back is bit-reversed too. This gives the LSB-first CRC-32 and CRC-32C forms. No final inversion is applied. Software inverts the result when the standard CRC-32C check value is wanted.

Top module: `crcw_engine`

## Requirements
- R1: After reset the start-value register reads 0xFFFFFFFF, the polynomial register reads 0x04C11DB7, the control register reads 0, and the data register reads 0xFFFFFFFF.
- R2: The registers sit at these offsets: data 0x00, control 0x08, start value 0x10, polynomial 0x14. The start-value and polynomial registers read back exactly what was written.
- R3: Writing control with bit 0 set loads the running checksum from the start-value register in that write's clock edge. Bit 0 always reads back as 0.
- R4: Control bits 7:5 are stored and read back, and every other control bit reads 0. Reflected mode is active only when all three of bits 7:5 are 1. Any other pattern leaves the engine in normal mode.
- R5: In normal mode, a write to the data register folds the word in MSB first in one clock. For each bit, the checksum shifts left, and the polynomial is XORed in when the bit shifted out differs from the data bit. A data read in the next cycle returns the new value.
- R6: In reflected mode, the input word is bit-reversed before it is folded in, and a data read returns the bit-reversed checksum.
- R7: Consecutive data writes chain on the running value without any further setup, including writes on back-to-back cycles.
- R8: No final XOR is applied. The following holds with reflected mode on, start value 0xFFFFFFFF and word 0x34333231 (the bytes "1234"). The value read equals the LSB-first byte-wise CRC register for generator 0xEDB88320 when the polynomial is 0x04C11DB7, and for 0x82F63B78 when the polynomial is 0x1EDC6F41.
- R9: Writes to unmapped offsets, and any cycle with req_i low, change nothing. Reads of unmapped offsets return 0.
- R10: A polynomial write takes effect for a data write in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the addressed register (combinational) |

## Verification
The single write port lets one control write change the reflection mode and reload the checksum in the same edge. The next data read must then apply the new output mapping to the reloaded value. The bench provokes this by writing all ones to control while reflected mode is off, then reading data at once. A polynomial write followed at once by a data write tests whether the fold uses the new generator on the next cycle. Each read is judged against a behavioural model of the registers, and against an independent LSB-first byte-wise CRC routine for the "1234" word.

// File: rtl/crcw_pkg.sv
package crcw_pkg;
  localparam int unsigned DW      = 32;
  localparam int unsigned OFF_DAT = 'h00;
  localparam int unsigned OFF_CTL = 'h08;
  localparam int unsigned OFF_INI = 'h10;
  localparam int unsigned OFF_PLY = 'h14;
  localparam int unsigned CTL_RLD = 0;
  localparam int unsigned REV_LSB = 5;
  localparam int unsigned REV_W   = 3;

  typedef struct packed {
    logic data_wr;
    logic reload;
  } crcw_cmd_t;
endpackage

// File: rtl/crcw_bitrev.sv
module crcw_bitrev #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] in_i,
  output logic [W-1:0] out_o
);
  for (genvar g = 0; g < W; g++) begin : g_rev
    assign out_o[g] = in_i[W-1-g];
  end
endmodule

// File: rtl/crcw_fold.sv
module crcw_fold #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] crc_i,
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] poly_i,
  output logic [W-1:0] crc_o
);
  logic [W-1:0] stage [W+1];
  assign stage[0] = crc_i;

  // one serial step per data bit, MSB first
  for (genvar g = 0; g < W; g++) begin : g_step
    logic fb;
    assign fb = stage[g][W-1] ^ data_i[W-1-g];
    assign stage[g+1] = {stage[g][W-2:0], 1'b0} ^ (fb ? poly_i : '0);
  end

  assign crc_o = stage[W];
endmodule

// File: rtl/crcw_regfile.sv
module crcw_regfile
  import crcw_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [DW-1:0] INIT_RST = 32'hFFFF_FFFF,
  parameter logic [DW-1:0] POLY_RST = 32'h04C1_1DB7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     init_o,
  output logic [DW-1:0]     poly_o,
  output logic              rev_o,
  output crcw_cmd_t         cmd_o,
  output logic              sel_dat_o,
  output logic              hit_o,
  output logic [DW-1:0]     rdata_o
);
  logic hit_dat, hit_ctl, hit_ini, hit_ply, wr;
  logic [DW-1:0]    init_q, poly_q;
  logic [REV_W-1:0] rev_q;

  assign hit_dat = addr_i == ADDR_W'(OFF_DAT);
  assign hit_ctl = addr_i == ADDR_W'(OFF_CTL);
  assign hit_ini = addr_i == ADDR_W'(OFF_INI);
  assign hit_ply = addr_i == ADDR_W'(OFF_PLY);
  assign hit_o   = hit_dat | hit_ctl | hit_ini | hit_ply;
  assign wr      = req_i & we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= INIT_RST;
      poly_q <= POLY_RST;
      rev_q  <= '0;
    end else if (wr) begin
      if (hit_ini) init_q <= wdata_i;
      if (hit_ply) poly_q <= wdata_i;
      if (hit_ctl) rev_q  <= wdata_i[REV_LSB +: REV_W];
    end
  end

  assign cmd_o.reload  = wr & hit_ctl & wdata_i[CTL_RLD];
  assign cmd_o.data_wr = wr & hit_dat;
  assign sel_dat_o     = hit_dat;
  assign init_o        = init_q;
  assign poly_o        = poly_q;
  assign rev_o         = &rev_q;

  always_comb begin
    rdata_o = '0;
    if (hit_ctl) rdata_o[REV_LSB +: REV_W] = rev_q;
    if (hit_ini) rdata_o = init_q;
    if (hit_ply) rdata_o = poly_q;
  end

  p_init_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && hit_ini) |=> $stable(init_q));
  p_poly_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && hit_ply) |=> $stable(poly_q));
endmodule

// File: rtl/crcw_engine.sv
module crcw_engine
  import crcw_pkg::*;
#(
  parameter int unsigned   ADDR_W   = 8,
  parameter logic [DW-1:0] INIT_RST = 32'hFFFF_FFFF,
  parameter logic [DW-1:0] POLY_RST = 32'h04C1_1DB7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o
);
  logic [DW-1:0] init, poly, reg_rdata, din_rev, din, crc_q, crc_nxt, crc_rev;
  logic          rev, sel_dat, hit;
  crcw_cmd_t     cmd;

  crcw_regfile #(.ADDR_W(ADDR_W), .INIT_RST(INIT_RST), .POLY_RST(POLY_RST)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .init_o(init), .poly_o(poly), .rev_o(rev), .cmd_o(cmd),
    .sel_dat_o(sel_dat), .hit_o(hit), .rdata_o(reg_rdata)
  );

  crcw_bitrev #(.W(DW)) u_rev_in  (.in_i(wdata_i), .out_o(din_rev));
  crcw_bitrev #(.W(DW)) u_rev_out (.in_i(crc_q),   .out_o(crc_rev));

  assign din = rev ? din_rev : wdata_i;

  crcw_fold #(.W(DW)) u_fold (.crc_i(crc_q), .data_i(din), .poly_i(poly), .crc_o(crc_nxt));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          crc_q <= INIT_RST;
    else if (cmd.reload)  crc_q <= init;
    else if (cmd.data_wr) crc_q <= crc_nxt;
  end

  always_comb begin
    if (sel_dat) rdata_o = rev ? crc_rev : crc_q;
    else         rdata_o = reg_rdata;
  end

  p_reload_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd.reload |=> crc_q == $past(init));
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd.reload && !cmd.data_wr |=> $stable(crc_q));
  p_unmapped_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && !hit |-> rdata_o == '0);
  p_onecmd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> !cmd.reload && !cmd.data_wr);
endmodule

// File: tb/crcw_engine_bench.sv
module crcw_engine_bench;
  logic        clk = 0, rst_n = 0, req = 0, we = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [31:0] m_init = 32'hFFFF_FFFF, m_poly = 32'h04C1_1DB7, m_crc = 32'hFFFF_FFFF;
  logic [2:0]  m_rev = '0;

  always #5 clk = ~clk;

  crcw_engine u_crcw_engine (.clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
                             .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata));

  function automatic logic [31:0] rv(input logic [31:0] x);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = x[31-i];
    return r;
  endfunction

  function automatic logic [31:0] mfold(input logic [31:0] c, input logic [31:0] d,
                                        input logic [31:0] p);
    for (int k = 31; k >= 0; k--) begin
      logic fb;
      fb = c[31] ^ d[k];
      c = c << 1;
      if (fb) c = c ^ p;
    end
    return c;
  endfunction

  // independent LSB-first byte-wise reference
  function automatic logic [31:0] refl(input logic [31:0] c, input logic [31:0] rp,
                                       input logic [31:0] w);
    for (int b = 0; b < 4; b++) begin
      c = c ^ {24'd0, w[8*b +: 8]};
      for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ rp) : (c >> 1);
    end
    return c;
  endfunction

  function automatic logic [31:0] mread(input logic [7:0] a);
    case (a)
      8'h00: return (&m_rev) ? rv(m_crc) : m_crc;
      8'h08: return {24'd0, m_rev, 5'd0};
      8'h10: return m_init;
      8'h14: return m_poly;
      default: return 32'd0;
    endcase
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    case (a)
      8'h00: m_crc = mfold(m_crc, (&m_rev) ? rv(d) : d, m_poly);
      8'h08: begin m_rev = d[7:5]; if (d[0]) m_crc = m_init; end
      8'h10: m_init = d;
      8'h14: m_poly = d;
      default: ;
    endcase
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    @(negedge clk);
    req = 1; we = 0; addr = a;
    #1 chk(rdata, mread(a), tag);
  endtask

  task automatic idle_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 0; we = 1; addr = a; wdata = d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(8'h00, "R1 data"); rd(8'h08, "R1 ctrl"); rd(8'h10, "R1 init"); rd(8'h14, "R1 poly");
    // R2 readback
    wr(8'h10, 32'h1234_5678); rd(8'h10, "R2 init");
    wr(8'h14, 32'h1EDC_6F41); rd(8'h14, "R2 poly");
    wr(8'h14, 32'h04C1_1DB7);
    // R3 reload, bit0 reads 0
    wr(8'h08, 32'h1); rd(8'h00, "R3 reload"); rd(8'h08, "R3 ctrl bit0");
    // R5/R7 normal mode, back-to-back chain
    wr(8'h00, 32'hDEAD_BEEF); rd(8'h00, "R5 fold");
    wr(8'h00, 32'h0000_0001); wr(8'h00, 32'h8000_0000); wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, "R7 chain");
    // R4 partial reversal pattern stays normal
    wr(8'h08, 32'hA1); rd(8'h08, "R4 partial rd"); wr(8'h00, 32'h0F0F_3355);
    rd(8'h00, "R4 partial normal");
    // R4/R6 mode change and reload in one write
    wr(8'h10, 32'hFFFF_FFFF); wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, "R4 mask"); rd(8'h00, "R6 reload+rev");
    wr(8'h00, 32'h3433_3231);
    rd(8'h00, "R6 refl fold");
    n_cmp++;
    if (rdata !== refl(32'hFFFF_FFFF, 32'hEDB8_8320, 32'h3433_3231)) begin
      n_bad++;
      $display("FAIL R8 crc32 act=%h exp=%h", rdata, refl(32'hFFFF_FFFF, 32'hEDB8_8320, 32'h3433_3231));
    end
    // R8/R10 poly write then data write next cycle
    wr(8'h08, 32'hE1); wr(8'h14, 32'h1EDC_6F41); wr(8'h00, 32'h3433_3231);
    rd(8'h00, "R10 poly next cycle");
    n_cmp++;
    if (rdata !== refl(32'hFFFF_FFFF, 32'h82F6_3B78, 32'h3433_3231)) begin
      n_bad++;
      $display("FAIL R8 crc32c act=%h exp=%h", rdata, refl(32'hFFFF_FFFF, 32'h82F6_3B78, 32'h3433_3231));
    end
    // R9 unmapped and req low
    wr(8'h04, 32'hCAFE_F00D); rd(8'h04, "R9 unmapped rd"); rd(8'h00, "R9 data kept");
    idle_wr(8'h10, 32'h0BAD_0BAD); idle_wr(8'h00, 32'h1111_1111);
    rd(8'h10, "R9 idle init"); rd(8'h00, "R9 idle data");
    @(negedge clk); req = 0;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule